// File: doc/BRIEF.md
# Dirty-Tracked Coprocessor Register Context Sequencer

This block holds a bank of eight optional 48-bit coprocessor registers and moves them between the bank and a context area in memory when the operating system switches processes. Each register carries a dirty bit that is set exactly when the register holds a non-zero value. A save command stores a flag word to memory, followed by the contents of only those registers whose flag is set. A restore command first fetches a flag word. It then loads only the registers that word marks, and it forces every unmarked register to zero. A switch therefore costs fewer bus beats when registers are unused, and no stale value from the previous process survives.

The memory side is a 16-bit port with request, write-enable, address, write data, read data and a ready handshake. Every 48-bit register crosses the port in three beats. The arithmetic users of the bank write registers through a simple write port and read them through a read port. Both ports are available while no sequence runs.

The controller is a state machine with six states. IDLE goes to SAVE_FLAGS on a save command, or to LOAD_FLAGS on a restore command. SAVE_FLAGS goes to SAVE_DATA when at least one flag is set, and to FINISH otherwise. SAVE_DATA stays in SAVE_DATA when it moves to the next set flag, and goes to FINISH after the last beat of the last flagged register. LOAD_FLAGS goes to LOAD_DATA or to FINISH by the same rule, using the flag word it has just read. LOAD_DATA follows the same pattern as SAVE_DATA. FINISH raises done for one cycle and returns to IDLE.

Top module: `ctx_sequencer`

## Requirements
- R1: After reset all eight registers read as zero, every dirty flag is clear, and busy, done and mem_req are low.
- R2: A user write while idle loads the addressed register. Its dirty flag becomes 1 if the written value is non-zero and 0 if it is zero.
- R3: A save command (cmd_save) starts a sequence whose first beat is a write to base_addr. The beat carries the flag word: bit i is the dirty flag of register i, and bits 15:8 are zero.
- R4: After the flag word, a save writes each flagged register in ascending index order as three beats, bits 15:0 first, then 31:16, then 47:32. Unflagged registers get no beats. Each beat's address is 2 above the previous one. Without stalls the beats occupy consecutive cycles.
- R5: A restore command (cmd_restore) starts a sequence whose first beat is a read from base_addr. Bits 7:0 of the returned word are the flags, and bits 15:8 are ignored.
- R6: After the flag word, a restore reads three beats (low half-word first) at consecutive 2-byte addresses for each flagged register, in ascending order. It loads the assembled value into that register, and the register's dirty flag becomes the OR of the loaded value.
- R7: During a restore, every register whose flag bit is clear becomes zero, and its dirty flag clears.
- R8: A beat completes only in a cycle where mem_req and mem_ready are both high. While mem_ready is low, mem_req, mem_we, mem_addr and the write data hold steady.
- R9: One cycle after the last beat completes, done is high for exactly one cycle. busy is low in the cycle after that.
- R10: While busy, cmd_save, cmd_restore and user writes are ignored. When both commands arrive together while idle, the save is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_save | input | 1 | Start a save sequence |
| cmd_restore | input | 1 | Start a restore sequence |
| base_addr | input | 24 | Byte address of the context area, captured with the command |
| rf_wr_en | input | 1 | User register write strobe |
| rf_wr_idx | input | 3 | User write register index |
| rf_wr_data | input | 48 | User write value |
| rf_rd_idx | input | 3 | User read register index |
| rf_rd_data | output | 48 | Value of the register selected by rf_rd_idx |
| dirty_flags | output | 8 | Dirty flag of each register |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 24 | Byte address of the beat |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory accepts or completes the beat |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at sequence end |

## Verification
The bench saves a bank where some registers were written back to zero. A design that tracked dirtiness by "ever written" would emit extra beats for those registers. It also saves an empty bank, which must produce a single flag beat, and a full bank, which must produce 25 back-to-back beats. An off-by-one in the index search or the beat counter would drop or repeat half-words. A restore with stale values in unflagged registers and junk in the flag word's upper byte catches designs that leave stale data behind or that misread the flags. A restore with an all-clear flag word must zero the whole bank after one read. A run with mem_ready toggling exposes advancing on request alone. Commands and writes sent mid-sequence show whether the busy guard works: a design without it would issue reads or corrupt a register during a save.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_FLAGS,
        ST_SAVE_DATA,
        ST_LOAD_FLAGS,
        ST_LOAD_DATA,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/ctx_regbank.sv
module ctx_regbank #(
    parameter int NREG = 8,
    parameter int DW   = 48,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            clr_en,
    input  logic [NREG-1:0] clr_keep,
    input  logic [IW-1:0]   rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [IW-1:0]   rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    output logic [NREG-1:0] dirty
);
    logic [NREG*DW-1:0] flat;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] val_q;
        logic          dirty_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q   <= '0;
                dirty_q <= 1'b0;
            end else if (clr_en && !clr_keep[g]) begin
                val_q   <= '0;
                dirty_q <= 1'b0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                val_q   <= wr_data;
                dirty_q <= |wr_data;
            end
        end

        assign flat[g*DW +: DW] = val_q;
        assign dirty[g]         = dirty_q;

        // R2: the stored flag always tracks whether the value is non-zero
        assert_dirty_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q == (|val_q));
    end

    assign rd_a_data = flat[int'(rd_a_idx)*DW +: DW];
    assign rd_b_data = flat[int'(rd_b_idx)*DW +: DW];
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
    import ctx_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 48,
    parameter int BW   = 16,
    parameter int AW   = 24,
    localparam int IW    = $clog2(NREG),
    localparam int BEATS = DW / BW,
    localparam int BCW   = $clog2(BEATS),
    localparam int CW    = $clog2(NREG * BEATS + 2),
    localparam int HW    = DW - BW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_save,
    input  logic            cmd_restore,
    input  logic [AW-1:0]   base_addr,
    input  logic [NREG-1:0] dirty,
    output logic [IW-1:0]   rd_idx,
    input  logic [DW-1:0]   rd_data,
    output logic            bank_wr_en,
    output logic [IW-1:0]   bank_wr_idx,
    output logic [DW-1:0]   bank_wr_data,
    output logic            clr_en,
    output logic [NREG-1:0] clr_keep,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [BW-1:0]   mem_wdata,
    input  logic [BW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done
);
    seq_state_t      state_q, state_d;
    logic [NREG-1:0] flags_q, flags_d;
    logic [IW-1:0]   idx_q, idx_d;
    logic [BCW-1:0]  beat_q, beat_d;
    logic [AW-1:0]   base_q, base_d;
    logic [CW-1:0]   offs_q, offs_d;
    logic [HW-1:0]   hold_q, hold_d;
    logic            fire;
    logic [IW:0]     nxt;

    function automatic logic [IW:0] first_set(input logic [NREG-1:0] f, input logic [IW:0] from);
        logic [IW:0] r;
        r = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (f[i] && (IW+1)'(i) >= from) r = {1'b1, IW'(i)};
        end
        return r;
    endfunction

    assign fire = mem_req && mem_ready;

    // next-state process
    always_comb begin
        state_d = state_q;
        flags_d = flags_q;
        idx_d   = idx_q;
        beat_d  = beat_q;
        base_d  = base_q;
        offs_d  = offs_q;
        hold_d  = hold_q;
        nxt     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_save) begin
                    flags_d = dirty;
                    base_d  = base_addr;
                    offs_d  = '0;
                    state_d = ST_SAVE_FLAGS;
                end else if (cmd_restore) begin
                    base_d  = base_addr;
                    offs_d  = '0;
                    state_d = ST_LOAD_FLAGS;
                end
            end
            ST_SAVE_FLAGS, ST_LOAD_FLAGS: begin
                if (fire) begin
                    if (state_q == ST_LOAD_FLAGS) flags_d = mem_rdata[NREG-1:0];
                    nxt    = first_set(flags_d, '0);
                    offs_d = offs_q + 1'b1;
                    idx_d  = nxt[IW-1:0];
                    beat_d = '0;
                    if (!nxt[IW])                      state_d = ST_FINISH;
                    else if (state_q == ST_SAVE_FLAGS) state_d = ST_SAVE_DATA;
                    else                               state_d = ST_LOAD_DATA;
                end
            end
            ST_SAVE_DATA, ST_LOAD_DATA: begin
                if (fire) begin
                    offs_d = offs_q + 1'b1;
                    if (state_q == ST_LOAD_DATA) hold_d = {mem_rdata, hold_q[HW-1:BW]};
                    if (beat_q == BCW'(BEATS - 1)) begin
                        nxt    = first_set(flags_q, {1'b0, idx_q} + 1'b1);
                        idx_d  = nxt[IW-1:0];
                        beat_d = '0;
                        if (!nxt[IW]) state_d = ST_FINISH;
                    end else begin
                        beat_d = beat_q + 1'b1;
                    end
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
            idx_q   <= '0;
            beat_q  <= '0;
            base_q  <= '0;
            offs_q  <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            flags_q <= flags_d;
            idx_q   <= idx_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
            offs_q  <= offs_d;
            hold_q  <= hold_d;
        end
    end

    // output process
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_wdata    = '0;
        bank_wr_en   = 1'b0;
        clr_en       = 1'b0;
        unique case (state_q)
            ST_SAVE_FLAGS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = BW'(flags_q);
            end
            ST_SAVE_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = rd_data[int'(beat_q)*BW +: BW];
            end
            ST_LOAD_FLAGS: begin
                mem_req = 1'b1;
                clr_en  = fire;
            end
            ST_LOAD_DATA: begin
                mem_req    = 1'b1;
                bank_wr_en = fire && (beat_q == BCW'(BEATS - 1));
            end
            default: ;
        endcase
        mem_addr     = base_q + AW'({offs_q, 1'b0});
        clr_keep     = mem_rdata[NREG-1:0];
        bank_wr_idx  = idx_q;
        bank_wr_data = {mem_rdata, hold_q};
        rd_idx       = idx_q;
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_FINISH);
    end

    assert_first_save_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_save) |=> (mem_req && mem_we && mem_addr == $past(base_addr)));

    assert_first_load_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_save && cmd_restore) |=> (mem_req && !mem_we && mem_addr == $past(base_addr)));

    assert_hold_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_hold_wdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> $stable(mem_wdata));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !done) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(2)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);
endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer #(
    parameter int NREG = 8,
    parameter int DW   = 48,
    parameter int BW   = 16,
    parameter int AW   = 24,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_save,
    input  logic            cmd_restore,
    input  logic [AW-1:0]   base_addr,
    input  logic            rf_wr_en,
    input  logic [IW-1:0]   rf_wr_idx,
    input  logic [DW-1:0]   rf_wr_data,
    input  logic [IW-1:0]   rf_rd_idx,
    output logic [DW-1:0]   rf_rd_data,
    output logic [NREG-1:0] dirty_flags,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [BW-1:0]   mem_wdata,
    input  logic [BW-1:0]   mem_rdata,
    input  logic            mem_ready,
    output logic            busy,
    output logic            done
);
    logic            seq_wr_en, seq_clr_en;
    logic [IW-1:0]   seq_wr_idx, seq_rd_idx;
    logic [DW-1:0]   seq_wr_data, seq_rd_data;
    logic [NREG-1:0] seq_clr_keep;
    logic            bank_wr_en;
    logic [IW-1:0]   bank_wr_idx;
    logic [DW-1:0]   bank_wr_data;

    // user writes reach the bank only while idle (R10)
    assign bank_wr_en   = busy ? seq_wr_en   : rf_wr_en;
    assign bank_wr_idx  = busy ? seq_wr_idx  : rf_wr_idx;
    assign bank_wr_data = busy ? seq_wr_data : rf_wr_data;

    ctx_regbank #(.NREG(NREG), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bank_wr_en),
        .wr_idx    (bank_wr_idx),
        .wr_data   (bank_wr_data),
        .clr_en    (seq_clr_en),
        .clr_keep  (seq_clr_keep),
        .rd_a_idx  (seq_rd_idx),
        .rd_a_data (seq_rd_data),
        .rd_b_idx  (rf_rd_idx),
        .rd_b_data (rf_rd_data),
        .dirty     (dirty_flags)
    );

    ctx_seq_fsm #(.NREG(NREG), .DW(DW), .BW(BW), .AW(AW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_save     (cmd_save),
        .cmd_restore  (cmd_restore),
        .base_addr    (base_addr),
        .dirty        (dirty_flags),
        .rd_idx       (seq_rd_idx),
        .rd_data      (seq_rd_data),
        .bank_wr_en   (seq_wr_en),
        .bank_wr_idx  (seq_wr_idx),
        .bank_wr_data (seq_wr_data),
        .clr_en       (seq_clr_en),
        .clr_keep     (seq_clr_keep),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ready    (mem_ready),
        .busy         (busy),
        .done         (done)
    );

    // R10: while saving, nothing changes the bank
    assert_save_freezes_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && mem_we) |=> $stable(dirty_flags));
endmodule

// File: tb/ctx_sequencer_tb.sv
module ctx_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_save, cmd_restore;
    logic [23:0] base_addr;
    logic        rf_wr_en;
    logic [2:0]  rf_wr_idx, rf_rd_idx;
    logic [47:0] rf_wr_data, rf_rd_data;
    logic [7:0]  dirty_flags;
    logic        mem_req, mem_we, mem_ready, busy, done;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;

    logic [47:0] model [8];
    logic [15:0] mem [32];
    logic [23:0] rd_base;
    logic [23:0] wlog_addr [64];
    logic [15:0] wlog_data [64];
    logic [23:0] rlog_addr [64];
    int          wn, rn;
    logic        stall_en, tog;

    always #4 clk = ~clk;

    ctx_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_save(cmd_save), .cmd_restore(cmd_restore),
        .base_addr(base_addr), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .dirty_flags(dirty_flags), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .busy(busy), .done(done)
    );

    // memory model
    logic [23:0] rd_off;
    assign rd_off    = (mem_addr - rd_base) >> 1;
    assign mem_rdata = mem[rd_off[4:0]];
    assign mem_ready = !stall_en || tog;

    always @(negedge clk) tog <= ~tog;

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                wlog_addr[wn] <= mem_addr;
                wlog_data[wn] <= mem_wdata;
                wn <= wn + 1;
            end else begin
                rlog_addr[rn] <= mem_addr;
                rn <= rn + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_flags();
        logic [7:0] f;
        for (int i = 0; i < 8; i++) f[i] = |model[i];
        return f;
    endfunction

    task automatic user_write(input int idx, input logic [47:0] v);
        rf_wr_en = 1'b1; rf_wr_idx = 3'(idx); rf_wr_data = v;
        @(negedge clk);
        rf_wr_en = 1'b0;
        model[idx] = v;
    endtask

    task automatic read_reg(input int idx, output logic [47:0] v);
        rf_rd_idx = 3'(idx);
        #1 v = rf_rd_data;
    endtask

    task automatic issue(input bit save, input bit rest, input logic [23:0] base);
        wn = 0; rn = 0;
        cmd_save = save; cmd_restore = rest; base_addr = base;
        @(negedge clk);
        cmd_save = 1'b0; cmd_restore = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "done reached", 64'(done), 64'd1);
        @(negedge clk);
        chk("R9", "done single pulse", 64'(done), 64'd0);
        chk("R9", "busy cleared", 64'(busy), 64'd0);
    endtask

    task automatic check_save_log(input logic [23:0] base);
        logic [7:0] f;
        int k;
        f = exp_flags();
        chk("R3", "flag beat addr", 64'(wlog_addr[0]), 64'(base));
        chk("R3", "flag beat data", 64'(wlog_data[0]), {56'd0, f});
        k = 1;
        for (int i = 0; i < 8; i++) begin
            if (f[i]) begin
                for (int b = 0; b < 3; b++) begin
                    chk("R4", "data beat addr", 64'(wlog_addr[k]), 64'(base + 24'(2 * k)));
                    chk("R4", "data beat value", 64'(wlog_data[k]), 64'(model[i][16*b +: 16]));
                    k++;
                end
            end
        end
        chk("R4", "beat count", 64'(wn), 64'(k));
        chk("R5", "no reads during save", 64'(rn), 64'd0);
    endtask

    task automatic check_bank();
        logic [47:0] v;
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk("R6", "register value", 64'(v), 64'(model[i]));
        end
        chk("R7", "dirty flags", 64'(dirty_flags), 64'(exp_flags()));
    endtask

    task automatic t_reset();
        logic [47:0] v;
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk("R1", "reg zero", 64'(v), 64'd0);
        end
        chk("R1", "flags", 64'(dirty_flags), 64'd0);
        chk("R1", "busy/done/req", {61'd0, busy, done, mem_req}, 64'd0);
    endtask

    task automatic t_user_write();
        user_write(1, 48'h1234_5678_9ABC);
        user_write(3, 48'h0000_0000_0001);
        user_write(6, 48'h8000_0000_0000);
        chk("R2", "flags after writes", 64'(dirty_flags), 64'h4A);
        user_write(3, 48'h0);
        chk("R2", "zero write clears flag", 64'(dirty_flags), 64'h42);
        check_bank();
    endtask

    task automatic t_save(input bit stall, input logic [23:0] base);
        int n;
        stall_en = stall;
        issue(1'b1, 1'b0, base);
        wait_done(n);
        check_save_log(base);
        stall_en = 1'b0;
    endtask

    task automatic t_save_all();
        int n;
        for (int i = 0; i < 8; i++) user_write(i, {8'(i + 1), 40'h00_1111_2222} ^ 48'(i));
        issue(1'b1, 1'b0, 24'h000400);
        wait_done(n);
        check_save_log(24'h000400);
        chk("R4", "back-to-back beats", 64'(n), 64'd25);
    endtask

    task automatic t_restore(input bit stall);
        int n;
        rd_base = 24'h000200;
        for (int i = 0; i < 32; i++) mem[i] = 16'hDEAD;
        mem[0] = 16'hFF81;
        mem[1] = 16'h0A0B; mem[2] = 16'h0C0D; mem[3] = 16'h0E0F;
        mem[4] = 16'h7001; mem[5] = 16'h7002; mem[6] = 16'h7003;
        stall_en = stall;
        issue(1'b0, 1'b1, rd_base);
        wait_done(n);
        stall_en = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        model[0] = 48'h0E0F_0C0D_0A0B;
        model[7] = 48'h7003_7002_7001;
        chk("R5", "read count", 64'(rn), 64'd7);
        for (int k = 0; k < 7; k++)
            chk("R6", "read addr", 64'(rlog_addr[k]), 64'(rd_base + 24'(2 * k)));
        chk("R5", "flag upper byte ignored", 64'(dirty_flags), 64'h81);
        check_bank();
    endtask

    task automatic t_restore_empty();
        int n;
        user_write(4, 48'hFFFF_FFFF_FFFF);
        rd_base = 24'h000300;
        mem[0] = 16'h0000;
        issue(1'b0, 1'b1, rd_base);
        wait_done(n);
        for (int i = 0; i < 8; i++) model[i] = '0;
        chk("R7", "single flag read", 64'(rn), 64'd1);
        check_bank();
    endtask

    task automatic t_busy_ignore();
        int n;
        logic [47:0] v;
        user_write(2, 48'h2222_3333_4444);
        user_write(5, 48'h5555_6666_7777);
        stall_en = 1'b1;
        issue(1'b1, 1'b1, 24'h000600);
        cmd_restore = 1'b1;
        rf_wr_en = 1'b1; rf_wr_idx = 3'd2; rf_wr_data = 48'hBAD0_BAD0_BAD0;
        @(negedge clk);
        cmd_restore = 1'b0; rf_wr_en = 1'b0;
        @(negedge clk);
        cmd_save = 1'b1;
        @(negedge clk);
        cmd_save = 1'b0;
        wait_done(n);
        stall_en = 1'b0;
        check_save_log(24'h000600);
        read_reg(2, v);
        chk("R10", "write while busy ignored", 64'(v), 64'(model[2]));
        chk("R10", "restore while busy ignored", 64'(rn), 64'd0);
        @(negedge clk);
        chk("R10", "no second sequence", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd_save = 1'b0; cmd_restore = 1'b0; base_addr = '0;
        rf_wr_en = 1'b0; rf_wr_idx = '0; rf_wr_data = '0; rf_rd_idx = '0;
        stall_en = 1'b0; tog = 1'b0; rd_base = '0; wn = 0; rn = 0;
        for (int i = 0; i < 8; i++) model[i] = '0;
        for (int i = 0; i < 32; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_user_write();
        t_save(1'b0, 24'h000100);
        t_save(1'b1, 24'h000180);
        for (int i = 0; i < 8; i++) user_write(i, 48'h0);
        t_save(1'b0, 24'h000140);
        t_save_all();
        t_restore(1'b0);
        t_restore(1'b1);
        t_restore_empty();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule